// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a sixteen-slot cache of page translations that sits in front of a data cache. A lookup brings a 32-bit virtual address and a read/write flag. In the same cycle, without a register in the path, the block returns four results: whether a translation was found, the 30-bit physical address, a miss exception and a write-protection exception. For a matching slot it also reports the slot's stored usage and modified flags.

Every slot keeps a virtual page tag, a physical page number, a valid flag, a write-permission flag, a usage ("referenced") flag and a modified ("dirty") flag. A lookup that succeeds marks its slot as used. A permitted write also marks the slot as modified. After a miss, a page walker or software installs the translation through a separate fill port. A fill goes to the lowest-numbered empty slot. When no slot is empty, it goes to the slot under a rotating pointer. A flush input empties the whole buffer in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: The virtual page number is vaddr[31:12] and the offset is vaddr[11:0]. On an allowed hit, lk_paddr equals {ppn[17:0], vaddr[11:0]} and lk_pa_valid is 1.
- R2: All slots are compared in parallel. A translation installed in any of the 16 slots is found by a lookup of its page number.
- R3: When several valid slots hold the same page number, the lowest-numbered one supplies the translation and the status.
- R4: A lookup that matches no valid slot drives lk_miss_exc=1 and lk_hit=0, with lk_pa_valid=0 and lk_paddr=0.
- R5: A write lookup that hits a slot with write permission 0 drives lk_wprot_exc=1, lk_hit=1, lk_pa_valid=0 and lk_paddr=0. A read of the same slot is allowed.
- R6: On a hit, lk_used shows the slot's stored usage flag. An allowed hit sets that flag, and the change is visible from the next cycle. A write-protected lookup leaves it unchanged.
- R7: On a hit, lk_dirty shows the slot's stored modified flag. Only an allowed write hit sets it. Reads and write-protected writes leave it unchanged.
- R8: A fill writes the page number, frame number and write permission, sets valid and clears the usage and modified flags. It targets the lowest-numbered invalid slot. A fill to a slot overrides a status update to that slot in the same cycle.
- R9: When all slots are valid, a fill replaces the slot under a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping from 15 to 0, only on such a replacing fill.
- R10: flush=1 invalidates every slot at the next edge. In that cycle it overrides any fill and status update, and it leaves the rotating pointer unchanged.
- R11: After reset every slot is invalid, so every lookup misses.
- R12: While lk_valid=0, lk_hit, lk_miss_exc, lk_wprot_exc, lk_pa_valid, lk_used and lk_dirty are 0 and lk_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a write |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A valid slot matched |
| lk_miss_exc | output | 1 | Translation miss exception |
| lk_wprot_exc | output | 1 | Write to a slot without write permission |
| lk_pa_valid | output | 1 | lk_paddr carries an allowed translation |
| lk_paddr | output | 30 | Physical address |
| lk_used | output | 1 | Stored usage flag of the matched slot |
| lk_dirty | output | 1 | Stored modified flag of the matched slot |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_wr_ok | input | 1 | Write permission of the new slot |

## Verification
The random phase draws page numbers from a small pool. This gives a mix of hits, misses and duplicate tags, and it shows whether priority and replacement work or only plain lookup. Reads and writes are mixed across slots with and without write permission. This separates allowed writes, which set the modified flag, from blocked ones, which raise the exception and leave both flags alone. The directed runs fill the buffer to capacity and past it, so the order of the first-empty and rotating choices is visible through later hits and misses. They also issue a flush together with a fill, which shows that the flush takes priority.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFS_W = 12;
    localparam int PA_W  = 30;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             wr_ok;
        logic             used;
        logic             dirty;
    } slot_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match import xlat_pkg::*; #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
    input  logic [VPN_W-1:0]              vpn_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tag_i[g] == vpn_i);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               full_o
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
    end

    assign full_o = &valid_i;
    assign idx_o  = full_o ? rr_i : free_idx;
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer import xlat_pkg::*; #(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss_exc,
    output logic             lk_wprot_exc,
    output logic             lk_pa_valid,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_used,
    output logic             lk_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr_ok
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic  [IDX_W-1:0]   rr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]            vld_vec;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_vec;
    logic                          m_hit;
    logic [IDX_W-1:0]              m_idx;
    logic [IDX_W-1:0]              v_idx;
    logic                          v_full;
    slot_t                         hs;
    logic                          allow;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign vld_vec[g] = st_q.slot[g].valid;
        assign tag_vec[g] = st_q.slot[g].vpn;
    end

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .valid_i (vld_vec),
        .tag_i   (tag_vec),
        .vpn_i   (lk_vaddr[VA_W-1:OFS_W]),
        .hit_o   (m_hit),
        .idx_o   (m_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i (vld_vec),
        .rr_i    (st_q.rr),
        .idx_o   (v_idx),
        .full_o  (v_full)
    );

    assign hs = st_q.slot[m_idx];

    always_comb begin
        lk_hit       = lk_valid && m_hit;
        lk_miss_exc  = lk_valid && !m_hit;
        lk_wprot_exc = lk_hit && lk_write && !hs.wr_ok;
        allow        = lk_hit && !lk_wprot_exc;
        lk_pa_valid  = allow;
        lk_paddr     = allow ? {hs.ppn, lk_vaddr[OFS_W-1:0]} : '0;
        lk_used      = lk_hit && hs.used;
        lk_dirty     = lk_hit && hs.dirty;

        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) st_d.slot[i].valid = 1'b0;
        end else begin
            if (allow) begin
                st_d.slot[m_idx].used = 1'b1;
                if (lk_write) st_d.slot[m_idx].dirty = 1'b1;
            end
            if (fill_en) begin
                st_d.slot[v_idx] = '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn,
                                     wr_ok: fill_wr_ok, used: 1'b0, dirty: 1'b0};
                if (v_full) st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        lk_valid,
    input logic        lk_write,
    input logic [31:0] lk_vaddr,
    input logic        lk_hit,
    input logic        lk_miss_exc,
    input logic        lk_wprot_exc,
    input logic        lk_pa_valid,
    input logic [29:0] lk_paddr,
    input logic        lk_used,
    input logic        lk_dirty
);
    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pa_valid |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss_exc));

    p_prot_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_wprot_exc |-> (lk_hit && lk_write && !lk_pa_valid && lk_paddr == '0));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss_exc && !lk_wprot_exc && !lk_pa_valid
                       && !lk_used && !lk_dirty && lk_paddr == '0));
endmodule

bind xlat_buffer xlat_buffer_chk u_chk (.*);

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss_exc, lk_wprot_exc, lk_pa_valid, lk_used, lk_dirty;
    logic [29:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [17:0] fill_ppn = '0;
    logic        fill_wr_ok = 1'b0;

    always #2 clk = ~clk;

    xlat_buffer u_xlat_buffer (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic        m_v [N];
    logic [19:0] m_vpn [N];
    logic [17:0] m_ppn [N];
    logic        m_wok [N];
    logic        m_used [N];
    logic        m_dirty [N];
    int          m_rr;

    logic [19:0] pool [24];

    function automatic int m_find(logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return m_rr;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
            m_wok[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
        end
        m_rr = 0;
    endtask

    // one cycle: drive after negedge, compare 1 ns later, then advance model
    task automatic step(input logic v, input logic w, input logic [31:0] va,
                        input logic f, input logic [19:0] fv, input logic [17:0] fp,
                        input logic fw, input logic fl, input string tag);
        int idx;
        int vic;
        bit full;
        logic e_hit, e_miss, e_wp, e_pav, e_used, e_dirty;
        logic [29:0] e_pa;
        logic [35:0] act, exp_v;
        @(negedge clk);
        lk_valid = v; lk_write = w; lk_vaddr = va;
        fill_en = f; fill_vpn = fv; fill_ppn = fp; fill_wr_ok = fw; flush = fl;
        #1;
        idx = m_find(va[31:12]);
        e_hit = v && (idx >= 0);
        e_miss = v && (idx < 0);
        e_wp = 0; e_used = 0; e_dirty = 0; e_pa = '0;
        if (e_hit) begin
            e_wp = w && !m_wok[idx];
            e_used = m_used[idx];
            e_dirty = m_dirty[idx];
            if (!e_wp) e_pa = {m_ppn[idx], va[11:0]};
        end
        e_pav = e_hit && !e_wp;
        act = {lk_hit, lk_miss_exc, lk_wprot_exc, lk_pa_valid, lk_used, lk_dirty, lk_paddr};
        exp_v = {e_hit, e_miss, e_wp, e_pav, e_used, e_dirty, e_pa};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else begin
            if (e_pav) begin
                m_used[idx] = 1;
                if (w) m_dirty[idx] = 1;
            end
            if (f) begin
                full = 1;
                for (int i = 0; i < N; i++) if (!m_v[i]) full = 0;
                vic = m_victim();
                m_v[vic] = 1; m_vpn[vic] = fv; m_ppn[vic] = fp;
                m_wok[vic] = fw; m_used[vic] = 0; m_dirty[vic] = 0;
                if (full) m_rr = (m_rr + 1) % N;
            end
        end
    endtask

    task automatic look(input logic w, input logic [31:0] va, input string tag);
        step(1, w, va, 0, '0, '0, 0, 0, tag);
    endtask

    task automatic fill(input logic [19:0] fv, input logic [17:0] fp, input logic fw,
                        input string tag);
        step(0, 0, '0, 1, fv, fp, fw, 0, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 / R4: empty after reset
        look(0, 32'h1234_5ABC, "R11 miss after reset");
        look(1, 32'hFFFF_F000, "R4 miss exception");
        // R12: idle outputs
        step(0, 1, 32'h1234_5ABC, 0, '0, '0, 0, 0, "R12 idle outputs");

        // R8 fill to first free slot, R1 address form, R6 usage, R7 dirty
        fill(20'h12345, 18'h2ABCD, 1, "R8 fill slot0");
        look(0, 32'h1234_5ABC, "R1 translated address");
        look(0, 32'h1234_5001, "R6 usage set by earlier hit");
        look(1, 32'h1234_5002, "R7 allowed write");
        look(0, 32'h1234_5003, "R7 dirty visible");

        // R5 write protection
        fill(20'h00777, 18'h00111, 0, "R8 fill slot1");
        look(1, 32'h0077_7010, "R5 protected write");
        look(0, 32'h0077_7020, "R5 read allowed, R7 dirty still clear");
        look(1, 32'h0077_7030, "R6 used after read");

        // R3 duplicate tag: slot0 keeps priority
        fill(20'h12345, 18'h3FFFF, 1, "R8 duplicate fill slot2");
        look(0, 32'h1234_5444, "R3 lowest slot wins");

        // R2: fill to capacity, every slot reachable
        for (int i = 3; i < N; i++) fill(20'hA0000 + 20'(i), 18'(i * 7), 1, "R8 fill rest");
        for (int i = 3; i < N; i++) look(0, {20'hA0000 + 20'(i), 12'h055}, "R2 each slot found");

        // R9 rotating replacement: slot0 then slot1
        fill(20'hBEEF0, 18'h12121, 1, "R9 replace slot0");
        look(0, 32'h1234_5444, "R9 slot0 gone, slot2 answers");
        fill(20'hBEEF1, 18'h13131, 1, "R9 replace slot1");
        look(0, 32'h0077_7000, "R9 slot1 gone");
        look(0, 32'hBEEF_1000, "R9 new slot1 hit");

        // R10 flush beats concurrent fill
        step(1, 0, 32'hBEEF_0000, 1, 20'h55555, 18'h1, 1, 1, "R10 flush cycle");
        look(0, 32'h5555_5000, "R10 fill dropped by flush");
        look(0, 32'hBEEF_1000, "R10 all invalid");

        // random phase
        for (int i = 0; i < 24; i++) pool[i] = 20'($urandom_range(0, 20'hFFFFF));
        for (int n = 0; n < 4000; n++) begin
            logic [19:0] vp;
            logic [19:0] fvp;
            vp = pool[$urandom_range(0, 23)];
            fvp = pool[$urandom_range(0, 23)];
            step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1,
                 {vp, 12'($urandom)},
                 $urandom_range(0, 5) == 0, fvp, 18'($urandom),
                 $urandom_range(0, 2) != 0, $urandom_range(0, 199) == 0,
                 "R1 R3 R5 R6 R7 R9 random mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule